// File: doc/BRIEF.md
# Streaming Job Engine Shell

A compute-module shell that sits behind a job dispatcher. After a one-cycle kick it pulls a fixed number of 32-bit words from an input stream, forms running sums of them, and pushes a fixed number of result words onto an output stream. Once the final result word has gone out, it pulses a completion flag for one cycle and returns to waiting for the next kick.

Both streams use a registered-ready handshake: a ready level granted in one cycle licenses a transfer in the following cycle only. On the input side a word is taken when `in_valid` is high and `in_ready` was high one cycle earlier. On the output side the shell raises `out_valid` only in a cycle that follows one in which `out_ready` was high. The consumer must accept every word shown with `out_valid` high.

The controller has five states. IDLE waits for `kick` and goes to LOAD. LOAD takes input words and goes to EMIT when the last one is taken. EMIT issues result words and goes to FLUSH when the last one is issued. FLUSH is the cycle in which the last word is shown, and it always goes to REPORT. REPORT raises `job_done` and always goes back to IDLE.

Top module: `job_engine_shell`

## Requirements
- R1: While `rst_n` is low, and after it rises until a kick arrives, `in_ready`, `out_valid` and `job_done` are all low.
- R2: In IDLE, `in_valid` has no effect and `in_ready` stays low.
- R3: An input word transfers exactly when `in_valid` is high and `in_ready` was high in the previous cycle.
- R4: `in_ready` never grants more than `N_IN` transfers per job. Once the last grant is used it stays low until the next kick.
- R5: `out_valid` is high only in a cycle that directly follows a cycle with `out_ready` high.
- R6: Output word k (counted from 0) equals the sum modulo 2^32 of input words 0 through (k mod `N_IN`), in order. With `ACCUM`=0 it equals input word (k mod `N_IN`).
- R7: `out_data` holds its value in every cycle where `out_valid` is low.
- R8: `job_done` is high for exactly one cycle per job, in the cycle directly after the one that carries the last output word.
- R9: A `kick` that arrives while a job is in progress is ignored: no extra input is taken and no second completion follows.
- R10: Each job produces exactly `N_OUT` output words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kick | input | 1 | Starts a job when the shell is idle |
| job_done | output | 1 | One-cycle completion pulse |
| in_data | input | BUS_W | Input stream word |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Grant for an input transfer in the next cycle |
| out_data | output | BUS_W | Result word |
| out_valid | output | 1 | Result word present, must be taken |
| out_ready | input | 1 | Grant for an output word in the next cycle |

## Verification
A wrong word counter shows up at the ports within one job. Either the shell takes a fifth input, which shows as `in_ready` high after the fourth grant, or it produces a short or long output burst, which shows as a wrong result value or a misplaced `job_done`. A broken accumulator corrupts the next `out_valid` word. A one-cycle slip in the handshake registers makes `out_valid` appear after a cycle with `out_ready` low. A controller that leaves IDLE on a late kick raises `in_ready` within two cycles of completion.

// File: rtl/job_engine_pkg.sv
package job_engine_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_EMIT   = 3'd2,
        ST_FLUSH  = 3'd3,
        ST_REPORT = 3'd4
    } eng_state_t;
endpackage

// File: rtl/job_in_port.sv
module job_in_port #(
    parameter int N_IN = 4,
    parameter int AW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          src_valid,
    output logic          src_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic          all_in
);
    localparam int CW = $clog2(N_IN + 1);
    localparam logic [CW:0] LIMIT = (CW + 1)'(N_IN);

    logic [CW-1:0] cnt_q, cnt_nx;
    logic [CW:0]   pending;
    logic          rdy_q, rdy_prev_q;

    // a grant seen last cycle licenses this cycle's transfer
    assign wr_en     = enable && src_valid && rdy_prev_q;
    assign all_in    = wr_en && (cnt_q == CW'(N_IN - 1));
    assign wr_idx    = cnt_q[AW-1:0];
    assign src_ready = rdy_q;

    always_comb begin
        cnt_nx  = wr_en ? cnt_q + CW'(1) : cnt_q;
        pending = {1'b0, cnt_nx} + {{CW{1'b0}}, rdy_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            rdy_q      <= 1'b0;
            rdy_prev_q <= 1'b0;
        end else if (!enable) begin
            cnt_q      <= '0;
            rdy_q      <= 1'b0;
            rdy_prev_q <= 1'b0;
        end else begin
            cnt_q      <= cnt_nx;
            rdy_q      <= (pending < LIMIT);
            rdy_prev_q <= rdy_q;
        end
    end

    assert_ready_off_outside_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !src_ready);
    assert_no_grant_after_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(N_IN)) |-> !src_ready);
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(N_IN));
endmodule

// File: rtl/job_result_store.sv
module job_result_store #(
    parameter int BUS_W = 32,
    parameter int N_IN  = 4,
    parameter int AW    = 2,
    parameter bit ACCUM = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_idx,
    output logic [BUS_W-1:0] rd_data
);
    logic [BUS_W-1:0] mem_q [N_IN];
    logic [BUS_W-1:0] word_in;

    generate
        if (ACCUM) begin : g_accum
            logic [BUS_W-1:0] acc_q;
            // index 0 restarts the running sum for a new job
            assign word_in = ((wr_idx == '0) ? '0 : acc_q) + wr_data;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     acc_q <= '0;
                else if (wr_en) acc_q <= word_in;
            end
        end else begin : g_ident
            assign word_in = wr_data;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_IN; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= word_in;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/job_out_port.sv
module job_out_port #(
    parameter int BUS_W = 32,
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int AW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             dst_ready,
    input  logic [BUS_W-1:0] rd_data,
    output logic [AW-1:0]    rd_idx,
    output logic             dst_valid,
    output logic [BUS_W-1:0] dst_data,
    output logic             last_issue
);
    localparam int OCW = $clog2(N_OUT + 1);

    logic [OCW-1:0]   cnt_q;
    logic [AW-1:0]    ridx_q;
    logic             valid_q;
    logic [BUS_W-1:0] data_q;
    logic             issue;

    assign issue      = enable && dst_ready;
    assign last_issue = issue && (cnt_q == OCW'(N_OUT - 1));
    assign rd_idx     = ridx_q;
    assign dst_valid  = valid_q;
    assign dst_data   = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ridx_q  <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= issue;
            if (issue) begin
                data_q <= rd_data;
                cnt_q  <= cnt_q + OCW'(1);
                ridx_q <= (ridx_q == AW'(N_IN - 1)) ? '0 : ridx_q + AW'(1);
            end else if (!enable) begin
                cnt_q  <= '0;
                ridx_q <= '0;
            end
        end
    end

    assert_valid_follows_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |-> $past(dst_ready));
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_valid |-> $stable(dst_data));
    assert_issue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (cnt_q < OCW'(N_OUT)));
endmodule

// File: rtl/job_engine_shell.sv
module job_engine_shell
    import job_engine_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter bit ACCUM = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    output logic             job_done,
    input  logic [BUS_W-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [BUS_W-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready
);
    localparam int AW = (N_IN > 1) ? $clog2(N_IN) : 1;

    eng_state_t       state_q, state_nx;
    logic             load_en, emit_en;
    logic             wr_en, all_in, last_issue;
    logic [AW-1:0]    wr_idx, rd_idx;
    logic [BUS_W-1:0] rd_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (kick)       state_nx = ST_LOAD;
            ST_LOAD:   if (all_in)     state_nx = ST_EMIT;
            ST_EMIT:   if (last_issue) state_nx = ST_FLUSH;
            ST_FLUSH:                  state_nx = ST_REPORT;
            ST_REPORT:                 state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        load_en  = (state_q == ST_LOAD);
        emit_en  = (state_q == ST_EMIT);
        job_done = (state_q == ST_REPORT);
    end

    job_in_port #(.N_IN(N_IN), .AW(AW)) u_in (
        .clk(clk), .rst_n(rst_n), .enable(load_en), .src_valid(in_valid),
        .src_ready(in_ready), .wr_en(wr_en), .wr_idx(wr_idx), .all_in(all_in)
    );

    job_result_store #(.BUS_W(BUS_W), .N_IN(N_IN), .AW(AW), .ACCUM(ACCUM)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(in_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    job_out_port #(.BUS_W(BUS_W), .N_IN(N_IN), .N_OUT(N_OUT), .AW(AW)) u_out (
        .clk(clk), .rst_n(rst_n), .enable(emit_en), .dst_ready(out_ready),
        .rd_data(rd_data), .rd_idx(rd_idx), .dst_valid(out_valid),
        .dst_data(out_data), .last_issue(last_issue)
    );

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |=> !job_done);
    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |-> ($past(out_valid) && !out_valid));
    assert_idle_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !in_ready);
    assert_busy_kick_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT && kick) |=> (state_q != ST_LOAD));
endmodule

// File: tb/test_job_engine_shell.sv
module test_job_engine_shell;
    localparam int BUS_W = 32;
    localparam int N_IN  = 4;
    localparam int N_OUT = 4;
    localparam int NV    = 5;

    // stimulus table: input words, input stall %, output stall %, late kick
    localparam logic [31:0] VEC_IN [NV][N_IN] = '{
        '{32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0004},
        '{32'hFFFF_FFFF, 32'h0000_0002, 32'h8000_0000, 32'h8000_0000},
        '{32'h1234_5678, 32'h0000_0000, 32'hDEAD_BEEF, 32'h0BAD_F00D},
        '{32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0001, 32'hFFFF_FFFF},
        '{32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 32'h0000_0040}
    };
    localparam int VEC_SSTALL [NV] = '{0, 50, 80, 20, 30};
    localparam int VEC_DSTALL [NV] = '{0, 50, 20, 80, 30};
    localparam bit VEC_KICK   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             kick = 1'b0;
    logic             job_done;
    logic [BUS_W-1:0] in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [BUS_W-1:0] out_data;
    logic             out_valid;
    logic             out_ready = 1'b0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    job_engine_shell #(.BUS_W(BUS_W), .N_IN(N_IN), .N_OUT(N_OUT), .ACCUM(1'b1)) i_job_engine_shell (
        .clk(clk), .rst_n(rst_n), .kick(kick), .job_done(job_done),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_probe(input string tag);
        in_valid  = 1'b1;
        in_data   = 32'hCAFE_0000;
        out_ready = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(!in_ready && !out_valid && !job_done, tag,
                  {29'd0, in_ready, out_valid, job_done}, 32'd0);
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
    endtask

    task automatic run_job(input int v);
        logic [31:0] exp [N_IN];
        logic [31:0] acc;
        logic [31:0] prev_data;
        int in_idx, out_idx, dones, last_cyc, done_cyc;
        bit src_rdy_prev, kicked, in_full_checked;
        acc = '0;
        for (int i = 0; i < N_IN; i++) begin
            acc    = acc + VEC_IN[v][i];
            exp[i] = acc;
        end
        in_idx = 0; out_idx = 0; dones = 0; last_cyc = -10; done_cyc = -1;
        src_rdy_prev = 1'b0; kicked = 1'b0; in_full_checked = 1'b0;
        prev_data = out_data;
        @(negedge clk);
        kick = 1'b1;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            kick = 1'b0;
            if (out_valid) begin
                check(out_ready, "R5 valid without prior ready", {31'd0, out_ready}, 32'd1);
                check(out_idx < N_OUT, "R10 extra output word", out_idx, N_OUT - 1);
                if (out_idx < N_OUT)
                    check(out_data == exp[out_idx % N_IN], "R6 result word", out_data, exp[out_idx % N_IN]);
                out_idx++;
                last_cyc = cyc;
            end else begin
                check(out_data == prev_data, "R7 data hold", out_data, prev_data);
            end
            prev_data = out_data;
            if (job_done) begin
                dones++;
                if (dones == 1) done_cyc = cyc;
                check(out_idx == N_OUT, "R10 count at done", out_idx, N_OUT);
                check(last_cyc == cyc - 1, "R8 done position", last_cyc, cyc - 1);
            end
            if (in_idx == N_IN && !in_full_checked) begin
                check(!in_ready, "R4 ready after fill", {31'd0, in_ready}, 32'd0);
                in_full_checked = 1'b1;
            end
            if (VEC_KICK[v] && !kicked && out_idx == 1) begin
                kick   = 1'b1;   // R9 late kick
                kicked = 1'b1;
            end
            // drive input side; transfer decided by last cycle's grant (R3)
            if (in_idx < N_IN && $urandom_range(99) >= VEC_SSTALL[v]) begin
                in_valid = 1'b1;
                in_data  = VEC_IN[v][in_idx];
                if (src_rdy_prev) in_idx++;
            end else begin
                in_valid = (in_idx >= N_IN);   // keep offering junk after fill
                in_data  = 32'h5A5A_0000 + 32'(cyc);
            end
            src_rdy_prev = in_ready;
            out_ready = ($urandom_range(99) >= VEC_DSTALL[v]);
            if (done_cyc >= 0 && cyc >= done_cyc + 5) break;
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
        kick      = 1'b0;
        check(dones == 1, "R8 single done", dones, 1);
        check(out_idx == N_OUT, "R10 word count", out_idx, N_OUT);
        check(in_idx == N_IN, "R3 input count", in_idx, N_IN);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!in_ready && !out_valid && !job_done, "R1 in reset",
              {29'd0, in_ready, out_valid, job_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!in_ready && !out_valid && !job_done, "R1 after release",
              {29'd0, in_ready, out_valid, job_done}, 32'd0);
        // R2: valid data while idle is ignored
        idle_probe("R2 idle ignores input");

        for (int v = 0; v < NV; v++) begin
            run_job(v);
            idle_probe(VEC_KICK[v] ? "R9 late kick ignored" : "R4 ready stays low");
        end

        // R1: reset in the middle of a job
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick      = 1'b0;
        in_valid  = 1'b1;
        in_data   = 32'h7;
        out_ready = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!in_ready && !out_valid && !job_done, "R1 mid-job reset",
              {29'd0, in_ready, out_valid, job_done}, 32'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        run_job(1);
        run_job(0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule